// File: doc/BRIEF.md
# Processor-Port Special Tag Stripper

This block sits on the path from the management processor into the switch. Each frame from the processor carries a four-byte special tag right after the two MAC addresses. The tag starts with a tag identifier whose upper twelve bits are 0x810 and whose low nibble is a destination port mask. A standard tag control field follows it. The block buffers the sixteen header bytes and reports the port mask before any output byte leaves. It then rebuilds the frame for one egress port and appends a freshly computed FCS.

The egress port's removal flag picks the edit. With the flag set, the whole special tag is deleted and short results are zero-padded to the Ethernet minimum. With the flag clear, the identifier becomes a standard 0x8100 VLAN TPID and a null VLAN ID is replaced with the processor port's default VID. Input frames carry no FCS. A frame whose header does not hold a special tag is flagged and forwarded with its bytes unchanged.

Top module: `sptag_strip`

## Requirements
- R1: After reset, out_valid and mask_valid are low and in_ready is high.
- R2: For a well-formed frame, mask_valid is high for exactly one cycle and mask_out equals the low nibble of frame byte 13. Bytes are numbered from 0, and bytes 12 and 13 hold the tag identifier most significant byte first. A mask of zero is reported as zero and means the destination is left to address lookup.
- R3: When bit egress_sel of strip_en is 1, bytes 12 to 15 are removed. If fewer than 60 bytes remain, zero bytes are added until 60 data bytes have been sent.
- R4: When bit egress_sel of strip_en is 0, bytes 12 and 13 are sent as 0x81 and 0x00, all other bytes keep their place, and no padding is added.
- R5: In the converted case the VLAN ID is the low nibble of byte 14 followed by byte 15. A nonzero ID is sent unchanged. A zero ID is replaced with port_vid, and the upper nibble of byte 14 is kept.
- R6: Every output frame ends with four FCS bytes. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result complemented) over all bytes sent before it, least significant byte first.
- R7: mask_valid is high exactly two cycles before the cycle in which out_sop is high.
- R8: A frame shorter than 16 bytes, or one whose bytes 12 and 13 lie outside 0x8100 to 0x810F, raises malformed together with mask_valid and gives mask_out 0. Its bytes are forwarded unchanged and unpadded, followed by a new FCS.
- R9: An input byte transfers only when in_valid and in_ready are both high. While idle, a byte without in_sop is discarded and produces no output. out_sop marks the first output byte, and out_eop marks the last FCS byte.
- R10: strip_en, egress_sel and port_vid are sampled when the in_sop byte transfers. Later changes within the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | NPORTS | Per-port tag removal flags |
| egress_sel | input | PSEL_W | Egress port whose removal flag applies |
| port_vid | input | 12 | Default VID of the processor port |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of an input frame |
| in_eop | input | 1 | Last byte of an input frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of a frame |
| out_eop | output | 1 | Last output byte (final FCS byte) |
| mask_valid | output | 1 | Port mask strobe, one cycle per frame |
| mask_out | output | 4 | Extracted destination port mask |
| malformed | output | 1 | Frame carries no valid special tag (with mask_valid) |

## Verification
Two events can fall on the same cycle: the end of header capture and the end of the frame. A 16-byte frame places in_eop on the last header byte, so the block must go straight from the header to padding or FCS without entering the body phase. A second collision is the padding decision landing on the final body byte. The sweep provokes it with stripped frames of 63, 64 and 65 input bytes, which need one pad byte, no pad byte and none respectively. Each case is judged by comparing the whole output byte sequence, FCS included, against a frame the bench rebuilds arithmetically from the requirements.

// File: rtl/sptag_pkg.sv
package sptag_pkg;

  localparam int TAG_POS   = 12;
  localparam int TAG_LEN   = 4;
  localparam int HDR_BYTES = TAG_POS + TAG_LEN;
  localparam int HSEL_W    = $clog2(HDR_BYTES);
  localparam int IDX_W     = HSEL_W + 1;
  localparam int VID_W     = 12;
  localparam int MASK_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP,
    ST_DEC,
    ST_HEAD,
    ST_BODY,
    ST_PAD,
    ST_FCS
  } st_e;

  // One byte of reflected CRC-32, processed bit by bit, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Byte k of the complemented CRC, least significant byte first.
  function automatic logic [7:0] fcs_pick(input logic [31:0] c, input logic [1:0] k);
    logic [31:0] f;
    f = ~c;
    case (k)
      2'd0:    return f[7:0];
      2'd1:    return f[15:8];
      2'd2:    return f[23:16];
      default: return f[31:24];
    endcase
  endfunction

  // Rewrite of one header byte when the tag is converted to a VLAN tag.
  function automatic logic [7:0] edit_tag_byte(input logic [IDX_W-1:0] idx,
                                               input logic [7:0] orig,
                                               input logic vid_null,
                                               input logic [VID_W-1:0] dvid);
    logic [7:0] b;
    b = orig;
    if (idx == IDX_W'(TAG_POS))          b = 8'h81;
    else if (idx == IDX_W'(TAG_POS + 1)) b = 8'h00;
    else if (idx == IDX_W'(TAG_POS + 2)) b = vid_null ? {orig[7:4], dvid[11:8]} : orig;
    else if (idx == IDX_W'(TAG_POS + 3)) b = vid_null ? dvid[7:0] : orig;
    return b;
  endfunction

endpackage

// File: rtl/sptag_hdr_buf.sv
module sptag_hdr_buf
  import sptag_pkg::*;
#(
  parameter int DEPTH = HDR_BYTES,
  parameter int SEL_W = HSEL_W
)(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  output logic [15:0]      tag_tpid,
  output logic [VID_W-1:0] tag_vid
);

  logic [7:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_sel] <= wr_data;
  end

  assign rd_data  = slot[rd_sel];
  assign tag_tpid = {slot[TAG_POS], slot[TAG_POS + 1]};
  assign tag_vid  = {slot[TAG_POS + 2][3:0], slot[TAG_POS + 3]};

endmodule

// File: rtl/sptag_tag_dec.sv
module sptag_tag_dec
  import sptag_pkg::*;
(
  input  logic [15:0]       tpid,
  input  logic [VID_W-1:0]  vid,
  input  logic [IDX_W-1:0]  hdr_len,
  output logic              bad,
  output logic [MASK_W-1:0] mask,
  output logic              vid_null
);

  logic short_hdr;
  logic tpid_miss;

  assign short_hdr = hdr_len < IDX_W'(HDR_BYTES);
  assign tpid_miss = tpid[15:4] != 12'h810;
  assign bad       = short_hdr || tpid_miss;
  assign mask      = tpid[MASK_W-1:0];
  assign vid_null  = (vid == '0);

endmodule

// File: rtl/sptag_crc.sv
module sptag_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  import sptag_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '1;
    else if (clr) crc <= '1;
    else if (en)  crc <= crc32_step(crc, din);
  end

endmodule

// File: rtl/sptag_strip.sv
module sptag_strip
  import sptag_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int PSEL_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  parameter int MIN_DATA = 60
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] strip_en,
  input  logic [PSEL_W-1:0] egress_sel,
  input  logic [VID_W-1:0]  port_vid,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              mask_valid,
  output logic [MASK_W-1:0] mask_out,
  output logic              malformed
);

  localparam int CNT_W = $clog2(MIN_DATA + 1);
  localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_DATA);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(TAG_POS - 1);
  localparam logic [IDX_W-1:0] IDX_SKIP = IDX_W'(HDR_BYTES);

  st_e st_q, st_d;

  logic [IDX_W-1:0]  wi_q, ri_q, hlen_q, wr_idx, ri_nx;
  logic              eop_seen_q, strip_q, bad_q, vnull_q;
  logic [VID_W-1:0]  dvid_q;
  logic [1:0]        fi_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;

  // named internal events
  logic acc, start_acc, cap_acc, cap_done, head_last, need_pad, strip_frame;

  logic [7:0]        hd_byte;
  logic [15:0]       tag_tpid;
  logic [VID_W-1:0]  tag_vid;
  logic              dec_bad, dec_vnull;
  logic [MASK_W-1:0] dec_mask;

  logic [31:0] crc_q;
  logic        crc_en;
  logic        emit_v, emit_sop, emit_eop;
  logic [7:0]  emit_d;

  logic        ov_q, osop_q, oeop_q;
  logic [7:0]  od_q;

  // handshake and capture events
  assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_CAP) || (st_q == ST_BODY);
  assign acc       = in_valid && in_ready;
  assign start_acc = (st_q == ST_IDLE) && acc && in_sop;
  assign cap_acc   = start_acc || ((st_q == ST_CAP) && acc);
  assign wr_idx    = (st_q == ST_IDLE) ? '0 : wi_q;
  assign cap_done  = cap_acc && (in_eop || (wr_idx == IDX_LAST));

  // header replay and length bookkeeping
  assign strip_frame = strip_q && !bad_q;
  assign ri_nx       = (strip_frame && (ri_q == IDX_PRE)) ? IDX_SKIP : ri_q + 1'b1;
  assign head_last   = ri_nx >= hlen_q;
  assign cnt_nx      = (cnt_q == CNT_MIN) ? cnt_q : cnt_q + 1'b1;
  assign need_pad    = strip_frame && (cnt_nx < CNT_MIN);

  sptag_hdr_buf #(
    .DEPTH (HDR_BYTES),
    .SEL_W (HSEL_W)
  ) u_buf (
    .clk      (clk),
    .wr_en    (cap_acc),
    .wr_sel   (wr_idx[HSEL_W-1:0]),
    .wr_data  (in_data),
    .rd_sel   (ri_q[HSEL_W-1:0]),
    .rd_data  (hd_byte),
    .tag_tpid (tag_tpid),
    .tag_vid  (tag_vid)
  );

  sptag_tag_dec u_dec (
    .tpid     (tag_tpid),
    .vid      (tag_vid),
    .hdr_len  (hlen_q),
    .bad      (dec_bad),
    .mask     (dec_mask),
    .vid_null (dec_vnull)
  );

  sptag_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q == ST_DEC),
    .en    (crc_en),
    .din   (emit_d),
    .crc   (crc_q)
  );

  // byte selection for the output register
  always_comb begin
    emit_v   = 1'b0;
    emit_sop = 1'b0;
    emit_eop = 1'b0;
    emit_d   = 8'h00;
    crc_en   = 1'b0;
    unique case (st_q)
      ST_HEAD: begin
        emit_v   = 1'b1;
        emit_sop = (ri_q == '0);
        emit_d   = (bad_q || strip_q) ? hd_byte
                                      : edit_tag_byte(ri_q, hd_byte, vnull_q, dvid_q);
        crc_en   = 1'b1;
      end
      ST_BODY: begin
        if (acc) begin
          emit_v = 1'b1;
          emit_d = in_data;
          crc_en = 1'b1;
        end
      end
      ST_PAD: begin
        emit_v = 1'b1;
        crc_en = 1'b1;
      end
      ST_FCS: begin
        emit_v   = 1'b1;
        emit_d   = fcs_pick(crc_q, fi_q);
        emit_eop = (fi_q == 2'd3);
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_acc) st_d = cap_done ? ST_DEC : ST_CAP;
      ST_CAP:  if (cap_done)  st_d = ST_DEC;
      ST_DEC:  st_d = ST_HEAD;
      ST_HEAD: begin
        if (head_last) begin
          if (eop_seen_q) st_d = need_pad ? ST_PAD : ST_FCS;
          else            st_d = ST_BODY;
        end
      end
      ST_BODY: if (acc && in_eop) st_d = need_pad ? ST_PAD : ST_FCS;
      ST_PAD:  if (!need_pad) st_d = ST_FCS;
      ST_FCS:  if (fi_q == 2'd3) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      wi_q       <= '0;
      ri_q       <= '0;
      hlen_q     <= '0;
      eop_seen_q <= 1'b0;
      strip_q    <= 1'b0;
      bad_q      <= 1'b0;
      vnull_q    <= 1'b0;
      dvid_q     <= '0;
      fi_q       <= '0;
      cnt_q      <= '0;
      ov_q       <= 1'b0;
      osop_q     <= 1'b0;
      oeop_q     <= 1'b0;
      od_q       <= '0;
    end else begin
      st_q <= st_d;
      if (cap_acc) begin
        wi_q   <= wr_idx + 1'b1;
        hlen_q <= wr_idx + 1'b1;
      end
      if (start_acc) begin
        strip_q <= strip_en[egress_sel];
        dvid_q  <= port_vid;
      end
      if (cap_done) eop_seen_q <= in_eop;
      if (st_q == ST_DEC) begin
        bad_q   <= dec_bad;
        vnull_q <= dec_vnull;
        ri_q    <= '0;
        cnt_q   <= '0;
      end
      if (st_q == ST_HEAD) ri_q <= ri_nx;
      if (crc_en) cnt_q <= cnt_nx;
      fi_q   <= (st_q == ST_FCS) ? fi_q + 1'b1 : 2'd0;
      ov_q   <= emit_v;
      osop_q <= emit_sop;
      oeop_q <= emit_eop;
      od_q   <= emit_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign out_sop    = osop_q;
  assign out_eop    = oeop_q;
  assign mask_valid = (st_q == ST_DEC);
  assign malformed  = (st_q == ST_DEC) && dec_bad;
  assign mask_out   = ((st_q == ST_DEC) && !dec_bad) ? dec_mask : '0;

endmodule

// File: rtl/sptag_strip_chk.sv
module sptag_strip_chk #(
  parameter int MIN_DATA = 60
)(
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic mask_valid,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop,
  input logic strip_frame
);

  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= '0;
    else if (out_valid) run_q <= out_sop ? 16'd1 : ((run_q == 16'hFFFF) ? run_q : run_q + 16'd1);
  end

  // R3: a stripped frame leaves with at least the minimum length
  a_r3_pad_min: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eop && strip_frame) |-> ((run_q + 16'd1) >= 16'(MIN_DATA + 4)));

  // R6: the four FCS bytes come back to back
  a_r6_fcs_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> ($past(out_valid) && $past(out_valid, 2) && $past(out_valid, 3)));

  // R7: mask strobe leads the first output byte by two cycles
  a_r7_mask_lead: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> $past(mask_valid, 2));

  // R9: frame markers sit on valid bytes, start and end apart
  a_r9_eop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_valid && !out_sop));

  // R9: no input byte transfers while the header is decoded
  a_r9_hold_in: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> !in_ready);

endmodule

bind sptag_strip sptag_strip_chk #(
  .MIN_DATA (MIN_DATA)
) u_sptag_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .mask_valid  (mask_valid),
  .out_valid   (out_valid),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .strip_frame (strip_frame)
);

// File: tb/sptag_strip_test.sv
`timescale 1ns/1ps
module sptag_strip_test;

  localparam int NPORTS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NPORTS-1:0] strip_en = '0;
  logic [1:0]        egress_sel = '0;
  logic [11:0]       port_vid = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic              out_valid, out_sop, out_eop;
  logic [7:0]        out_data;
  logic              mask_valid, malformed;
  logic [3:0]        mask_out;

  always #5 clk = ~clk;

  sptag_strip #(.NPORTS(NPORTS)) uut (
    .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .egress_sel(egress_sel),
    .port_vid(port_vid), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .mask_valid(mask_valid), .mask_out(mask_out),
    .malformed(malformed)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [7:0] fin   [0:127];
  logic [7:0] exp_b [0:255];
  logic [7:0] got_b [0:255];
  int  exp_n, got_n, eop_n, mv_n;
  bit  exp_bad, got_bad, sop_after_mask;
  logic [3:0] exp_mask, got_mask;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mask_valid) begin
        mv_n++;
        got_mask = mask_out;
        got_bad  = malformed;
      end
      if (out_valid) begin
        if (out_sop) sop_after_mask = (mv_n > 0);
        if (got_n < 256) got_b[got_n] = out_data;
        got_n++;
        if (out_eop) eop_n++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // arithmetic model of the rebuilt frame
  task automatic build_exp(input int len, input bit strip, input logic [11:0] vid);
    bit vn;
    int n;
    logic [7:0] b;
    logic [31:0] c;
    exp_bad  = (len < 16) || (fin[12] != 8'h81) || (fin[13][7:4] != 4'h0);
    exp_mask = exp_bad ? 4'h0 : fin[13][3:0];
    vn = ({fin[14][3:0], fin[15]} == 12'h000);
    n = 0;
    for (int i = 0; i < len; i++) begin
      b = fin[i];
      if (!exp_bad && strip && i >= 12 && i <= 15) continue;
      if (!exp_bad && !strip) begin
        if (i == 12) b = 8'h81;
        if (i == 13) b = 8'h00;
        if (vn && i == 14) b = {fin[14][7:4], vid[11:8]};
        if (vn && i == 15) b = vid[7:0];
      end
      exp_b[n] = b;
      n++;
    end
    if (!exp_bad && strip) begin
      while (n < 60) begin
        exp_b[n] = 8'h00;
        n++;
      end
    end
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, exp_b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) begin
      exp_b[n] = c[8*k +: 8];
      n++;
    end
    exp_n = n;
  endtask

  task automatic run_frame(input int len, input int sel, input logic [NPORTS-1:0] sen,
                           input logic [11:0] vid, input bit gap, input bit flip,
                           input string tag);
    int i;
    int mis;
    int wait_c;
    bit tgl;
    build_exp(len, sen[sel], vid);
    @(posedge clk);
    got_n = 0; eop_n = 0; mv_n = 0; sop_after_mask = 1'b0;
    got_mask = 4'hF; got_bad = 1'b0;
    @(negedge clk);
    strip_en = sen; egress_sel = 2'(sel); port_vid = vid;
    i = 0; tgl = 1'b0;
    while (i < len) begin
      if (gap && tgl) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_data  = fin[i];
        in_sop   = (i == 0);
        in_eop   = (i == len - 1);
        if (in_ready) i++;
        if (flip && i == 3) begin
          strip_en = ~sen;
          port_vid = ~vid;
        end
      end
      tgl = ~tgl;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    wait_c = 0;
    while (eop_n == 0 && wait_c < 600) begin
      @(posedge clk);
      wait_c++;
    end
    @(posedge clk);
    chk(eop_n == 1, {tag, " R9 frame end count"}, eop_n, 1);
    if (got_n != exp_n) chk(1'b0, {tag, " length"}, got_n, exp_n);
    else begin
      mis = -1;
      for (int j = 0; j < got_n; j++) if (mis < 0 && got_b[j] !== exp_b[j]) mis = j;
      if (mis < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, {tag, " byte"}, int'(got_b[mis]), int'(exp_b[mis]));
    end
    chk(mv_n == 1 && got_mask == exp_mask && got_bad == exp_bad, "R2 R8 mask strobe",
        {mv_n, got_bad, got_mask}, {32'd1, exp_bad, exp_mask});
    chk(sop_after_mask, "R7 mask before first byte", sop_after_mask, 1);
  endtask

  task automatic fill(input int len, input int seed, input logic [3:0] msk, input bit vnull);
    for (int i = 0; i < 128; i++) fin[i] = 8'((i * 7 + seed * 13 + 1));
    fin[12] = 8'h81;
    fin[13] = {4'h0, msk};
    fin[14] = vnull ? 8'hA0 : 8'h53;
    fin[15] = vnull ? 8'h00 : 8'h2C;
    if (len < 0) fin[0] = 8'h00;
  endtask

  initial begin
    int lens [13] = '{1, 5, 12, 15, 16, 17, 20, 40, 59, 63, 64, 65, 80};
    string tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!out_valid && !mask_valid && in_ready, "R1 reset state",
        {out_valid, mask_valid, in_ready}, 3'b001);

    for (int li = 0; li < 13; li++) begin
      for (int s = 0; s < 2; s++) begin
        int sel;
        logic [NPORTS-1:0] sen;
        sel = li % 4;
        sen = s ? (4'b0001 << sel) : ~(4'b0001 << sel);
        fill(lens[li], li * 2 + s, 4'((li + s) % 16), ((li + s) % 2) == 0);
        if (lens[li] < 16) tg = "R8 R6 short";
        else if (s != 0) tg = "R3 R6 strip";
        else tg = "R4 R5 R6 convert";
        run_frame(lens[li], sel, sen, 12'(12'h100 + li * 5), (li % 3) == 0, 1'b0, tg);
      end
    end

    // R8: tag identifier out of range
    fill(30, 40, 4'h3, 1'b0); fin[13] = 8'h13;
    run_frame(30, 1, 4'b0010, 12'h055, 1'b0, 1'b0, "R8 tpid 0x8113");
    fill(30, 41, 4'h3, 1'b0); fin[12] = 8'h88;
    run_frame(30, 2, 4'b0000, 12'h055, 1'b0, 1'b0, "R8 tpid 0x8803");
    // R2: zero mask reported as zero
    fill(24, 42, 4'h0, 1'b0);
    run_frame(24, 0, 4'b0000, 12'h321, 1'b0, 1'b0, "R2 R4 zero mask");
    // R5: largest VID substituted
    fill(18, 43, 4'hF, 1'b1);
    run_frame(18, 3, 4'b0111, 12'hFFF, 1'b1, 1'b0, "R5 vid fff");
    // R10: configuration flipped after the start byte
    fill(30, 44, 4'h5, 1'b1);
    run_frame(30, 1, 4'b0010, 12'h0AB, 1'b0, 1'b1, "R10 strip held");
    fill(30, 45, 4'h6, 1'b1);
    run_frame(30, 2, 4'b0000, 12'h0CD, 1'b1, 1'b1, "R10 convert held");

    // R9: stray bytes without a start marker are discarded
    @(posedge clk);
    got_n = 0; mv_n = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (k == 2); in_data = 8'(k + 9);
      @(negedge clk);
    end
    in_valid = 1'b0; in_eop = 1'b0;
    repeat (6) @(negedge clk);
    chk(got_n == 0 && mv_n == 0, "R9 stray bytes ignored", got_n + mv_n, 0);
    fill(20, 46, 4'h9, 1'b0);
    run_frame(20, 0, 4'b0001, 12'h010, 1'b0, 1'b0, "R9 R3 after stray");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule